// File: doc/BRIEF.md
# Strided Write Traffic Generator for an AXI Memory Port

This block is the write half of a memory bandwidth exerciser. It sits directly on one AXI memory port and shares that port's clock. It accepts a single write job and then drives the write address, write data and write response channels at the highest rate the port allows.

A job is described by five values: a base byte address, a burst count, and three base-two logarithms. These give the burst size in bytes, the stride between bursts, and the size of the window that the addresses wrap inside. The i-th burst goes to the base plus (i × stride) reduced modulo the window size. Because the window is a power of two, that reduction is a bit mask applied to a running offset, so no multiplier is needed.

The address and data valid lines are held high until every burst has been handed over. The job finishes only when every write has been acknowledged. It then reports a done flag, the number of cycles the job took, and a sticky flag that records any error response. Only one job runs at a time.

Top module: `axi_stride_writer`

## Requirements
- R1: The address of burst i (counting from 0) is task_addr + ((i << task_stride_lg) & ((1 << task_wset_lg) − 1)), computed modulo 2^ADDR_W, so addresses wrap inside a window of 2^task_wset_lg bytes.
- R2: Every burst carries awlen = 2^(L − log2(DATA_W/8)) − 1 and awsize = log2(DATA_W/8), with awburst = 2'b01 (incrementing). L is task_burst_lg clamped into [log2(DATA_W/8), log2(DATA_W/8)+8]: a burst never holds fewer than one bus beat and never more than 256 beats.
- R3: Each burst sends exactly awlen+1 data beats with wstrb all ones, and wlast is high on the final beat of each burst and on no other beat.
- R4: From the first busy cycle, awvalid stays high with no gap until all task_count addresses are accepted, and wvalid stays high until all data beats are accepted. While valid is high and ready is low, the address, data and wlast values do not change.
- R5: bready is high while busy. The job ends only after task_count responses have been accepted. In the cycle after the last response handshake, busy is low and done is high.
- R6: cycles equals the number of clock edges from the edge that accepts task_start to the edge that accepts the last response, and it stays constant while done is high.
- R7: A response with bresp != 2'b00 sets err. err stays set until the next job is accepted, and accepting a job clears it.
- R8: A task_start pulse while busy is ignored: the running job keeps its parameters and burst count.
- R9: A job with task_count = 0 issues no traffic, and done is high with cycles = 0 in the cycle after acceptance.
- R10: After reset, busy, done, err, awvalid and wvalid are low and cycles is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the AXI port |
| rst_n | input | 1 | Synchronous active-low reset |
| task_start | input | 1 | Pulse: accept a job when not busy |
| task_addr | input | ADDR_W | Base byte address |
| task_count | input | CNT_W | Number of write bursts |
| task_burst_lg | input | LOG_W | log2 of the burst size in bytes |
| task_stride_lg | input | LOG_W | log2 of the stride in bytes |
| task_wset_lg | input | LOG_W | log2 of the wrap window in bytes |
| busy | output | 1 | A job is running |
| done | output | 1 | Last job has finished |
| err | output | 1 | Sticky error-response flag |
| cycles | output | 64 | Elapsed cycles of the last job |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Beats per burst minus one |
| m_awsize | output | 3 | log2 of bytes per beat |
| m_awburst | output | 2 | Burst type (incrementing) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes |
| m_wlast | output | 1 | Final beat of a burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
A wrong running offset shows up on m_awaddr at the next address handshake as a step that is not the stride modulo the window. A slipped beat counter moves wlast on the first affected burst, and this is visible as soon as that burst's data is accepted. A response counter that is off by one either ends the job a cycle before the last acknowledgement or never ends it. Either fault shows in done and cycles right after the final response, so every job is checked against a slave model that accepts and acknowledges bursts at varied rates.

// File: rtl/axi_swr_pkg.sv
package axi_swr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } swr_state_e;

   localparam logic [1:0] RESP_OKAY  = 2'b00;
   localparam logic [1:0] BURST_INCR = 2'b01;
   localparam int         MAX_LEN_LG = 8;

endpackage

// File: rtl/axi_swr_addr.sv
module axi_swr_addr
   import axi_swr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int BUS_LG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              run_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] stride_i,
   input  logic [ADDR_W-1:0] mask_i,
   input  logic [7:0]        len_i,
   input  logic              awready_i,
   output logic              awvalid_o,
   output logic [ADDR_W-1:0] awaddr_o,
   output logic [7:0]        awlen_o,
   output logic [2:0]        awsize_o,
   output logic [1:0]        awburst_o
);

   logic [CNT_W-1:0]  left_q;
   logic [ADDR_W-1:0] off_q;
   logic              hs;

   assign awvalid_o = run_i && (left_q != '0);
   assign hs        = awvalid_o && awready_i;
   assign awaddr_o  = base_i + (off_q & mask_i);
   assign awlen_o   = len_i;
   assign awsize_o  = 3'(BUS_LG);
   assign awburst_o = BURST_INCR;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         off_q  <= '0;
      end else if (load_i) begin
         left_q <= cnt_i;
         off_q  <= '0;
      end else if (hs) begin
         left_q <= left_q - 1'b1;
         off_q  <= off_q + stride_i;
      end
   end

   // consecutive addresses differ by the stride modulo the window (R1)
   p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && left_q > CNT_W'(1)) |=>
         (((awaddr_o - $past(awaddr_o)) & mask_i) == (stride_i & mask_i)))
      else $error("address step differs from stride");

   // address channel is never dropped between bursts (R4)
   p_aw_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && left_q > CNT_W'(1)) |=> awvalid_o)
      else $error("awvalid dropped mid job");

   // stalled address held stable (R4)
   p_aw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid_o && !awready_i) |=> (awvalid_o && $stable(awaddr_o)))
      else $error("address changed under backpressure");

endmodule

// File: rtl/axi_swr_data.sv
module axi_swr_data #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic                run_i,
   input  logic [CNT_W-1:0]    cnt_i,
   input  logic [7:0]          len_i,
   input  logic                wready_i,
   output logic                wvalid_o,
   output logic [DATA_W-1:0]   wdata_o,
   output logic [DATA_W/8-1:0] wstrb_o,
   output logic                wlast_o
);

   localparam int LANES = DATA_W / 32;

   logic [CNT_W-1:0] left_q;
   logic [CNT_W-1:0] idx_q;
   logic [7:0]       beat_q;
   logic             hs;
   logic [31:0]      tag;

   assign wvalid_o = run_i && (left_q != '0);
   assign wlast_o  = wvalid_o && (beat_q == len_i);
   assign hs       = wvalid_o && wready_i;
   assign wstrb_o  = '1;
   assign tag      = (32'(idx_q) << 8) | 32'(beat_q);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wdata_o[g*32 +: 32] = tag + 32'(g);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         idx_q  <= '0;
         beat_q <= '0;
      end else if (load_i) begin
         left_q <= cnt_i;
         idx_q  <= '0;
         beat_q <= '0;
      end else if (hs) begin
         if (beat_q == len_i) begin
            beat_q <= '0;
            left_q <= left_q - 1'b1;
            idx_q  <= idx_q + 1'b1;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   // stalled beat held stable (R4)
   p_w_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wvalid_o && !wready_i) |=>
         (wvalid_o && $stable(wdata_o) && $stable(wlast_o)))
      else $error("data changed under backpressure");

   // data channel stays busy until every burst is sent (R4)
   p_w_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && left_q > CNT_W'(1)) |=> wvalid_o)
      else $error("wvalid dropped mid job");

   // a beat that is not last is followed by more beats of the burst (R3)
   p_burst_cont_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && !wlast_o) |=> wvalid_o)
      else $error("burst cut short");

endmodule

// File: rtl/axi_swr_resp.sv
module axi_swr_resp
   import axi_swr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             bvalid_i,
   input  logic [1:0]       bresp_i,
   output logic             bready_o,
   output logic             last_o,
   output logic             err_o
);

   logic [CNT_W-1:0] left_q;
   logic             err_q;
   logic             hs;

   assign bready_o = run_i;
   assign hs       = bvalid_i && bready_o;
   assign last_o   = hs && (left_q == CNT_W'(1));
   assign err_o    = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
         err_q  <= 1'b0;
      end else if (load_i) begin
         left_q <= cnt_i;
         err_q  <= 1'b0;
      end else if (hs) begin
         left_q <= left_q - 1'b1;
         if (bresp_i != RESP_OKAY) err_q <= 1'b1;
      end
   end

   // no response beyond the outstanding count (R5)
   p_no_extra_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid_i && bready_o) |-> (left_q != '0))
      else $error("response with nothing outstanding");

   // error flag is sticky until a new job (R7)
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !load_i) |=> err_q)
      else $error("error flag lost");

endmodule

// File: rtl/axi_stride_writer.sv
module axi_stride_writer
   import axi_swr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int CNT_W  = 16,
   parameter int LOG_W  = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                task_start,
   input  logic [ADDR_W-1:0]   task_addr,
   input  logic [CNT_W-1:0]    task_count,
   input  logic [LOG_W-1:0]    task_burst_lg,
   input  logic [LOG_W-1:0]    task_stride_lg,
   input  logic [LOG_W-1:0]    task_wset_lg,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [63:0]         cycles,
   output logic                m_awvalid,
   input  logic                m_awready,
   output logic [ADDR_W-1:0]   m_awaddr,
   output logic [7:0]          m_awlen,
   output logic [2:0]          m_awsize,
   output logic [1:0]          m_awburst,
   output logic                m_wvalid,
   input  logic                m_wready,
   output logic [DATA_W-1:0]   m_wdata,
   output logic [DATA_W/8-1:0] m_wstrb,
   output logic                m_wlast,
   input  logic                m_bvalid,
   output logic                m_bready,
   input  logic [1:0]          m_bresp
);

   localparam int BUS_BYTES = DATA_W / 8;
   localparam int BUS_LG    = $clog2(BUS_BYTES);
   localparam int MAX_LG    = BUS_LG + MAX_LEN_LG;

   initial begin
      assert (DATA_W >= 32 && DATA_W % 32 == 0 && (1 << BUS_LG) == BUS_BYTES)
         else $error("DATA_W must be a power of two of at least 32");
      assert (ADDR_W >= 8 && ADDR_W <= 64) else $error("ADDR_W out of range");
      assert (CNT_W >= 2) else $error("CNT_W too small");
      assert ((1 << LOG_W) > MAX_LG) else $error("LOG_W too narrow");
   end

   swr_state_e        state_q;
   logic [ADDR_W-1:0] base_q, stride_q, mask_q;
   logic [7:0]        len_q;
   logic [63:0]       cyc_q;
   logic              accept, run, last_resp;
   logic [LOG_W-1:0]  blg_c;
   logic [7:0]        len_c;

   assign run    = (state_q == ST_RUN);
   assign accept = task_start && !run;

   // clamp burst size into one beat .. 256 beats
   always_comb begin
      if (task_burst_lg < LOG_W'(BUS_LG))      blg_c = LOG_W'(BUS_LG);
      else if (task_burst_lg > LOG_W'(MAX_LG)) blg_c = LOG_W'(MAX_LG);
      else                                     blg_c = task_burst_lg;
      len_c = 8'((9'(1) << (blg_c - LOG_W'(BUS_LG))) - 9'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         base_q   <= '0;
         stride_q <= '0;
         mask_q   <= '0;
         len_q    <= '0;
         cyc_q    <= '0;
      end else if (accept) begin
         state_q  <= (task_count == '0) ? ST_DONE : ST_RUN;
         base_q   <= task_addr;
         stride_q <= ADDR_W'(1) << task_stride_lg;
         mask_q   <= (ADDR_W'(1) << task_wset_lg) - ADDR_W'(1);
         len_q    <= len_c;
         cyc_q    <= '0;
      end else if (run) begin
         cyc_q <= cyc_q + 64'd1;
         if (last_resp) state_q <= ST_DONE;
      end
   end

   assign busy   = run;
   assign done   = (state_q == ST_DONE);
   assign cycles = cyc_q;

   axi_swr_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_LG(BUS_LG)) u_addr (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .run_i(run),
      .cnt_i(task_count), .base_i(base_q), .stride_i(stride_q),
      .mask_i(mask_q), .len_i(len_q), .awready_i(m_awready),
      .awvalid_o(m_awvalid), .awaddr_o(m_awaddr), .awlen_o(m_awlen),
      .awsize_o(m_awsize), .awburst_o(m_awburst)
   );

   axi_swr_data #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_data (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .run_i(run),
      .cnt_i(task_count), .len_i(len_q), .wready_i(m_wready),
      .wvalid_o(m_wvalid), .wdata_o(m_wdata), .wstrb_o(m_wstrb),
      .wlast_o(m_wlast)
   );

   axi_swr_resp #(.CNT_W(CNT_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .run_i(run),
      .cnt_i(task_count), .bvalid_i(m_bvalid), .bresp_i(m_bresp),
      .bready_o(m_bready), .last_o(last_resp), .err_o(err)
   );

   // elapsed count frozen once finished (R6)
   p_cycles_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !task_start) |=> (done && $stable(cycles)))
      else $error("cycle count moved after completion");

   // start while running leaves the job untouched (R8)
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && task_start) |=> ($stable(base_q) && $stable(len_q) && $stable(mask_q)))
      else $error("job parameters changed while busy");

endmodule

// File: tb/axi_stride_writer_tb_top.sv
module axi_stride_writer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int DATA_W = 64;
   localparam int CNT_W  = 16;
   localparam int LOG_W  = 6;
   localparam int BUS_LG = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic task_start = 1'b0;
   logic [ADDR_W-1:0] task_addr = '0;
   logic [CNT_W-1:0]  task_count = '0;
   logic [LOG_W-1:0]  task_burst_lg = '0, task_stride_lg = '0, task_wset_lg = '0;
   logic busy, done, err;
   logic [63:0] cycles;
   logic m_awvalid, m_awready, m_wvalid, m_wready, m_wlast, m_bvalid, m_bready;
   logic [ADDR_W-1:0] m_awaddr;
   logic [7:0] m_awlen;
   logic [2:0] m_awsize;
   logic [1:0] m_awburst, m_bresp;
   logic [DATA_W-1:0] m_wdata;
   logic [DATA_W/8-1:0] m_wstrb;

   always #(CLK_PERIOD/2) clk = ~clk;

   axi_stride_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LOG_W(LOG_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_addr(task_addr),
      .task_count(task_count), .task_burst_lg(task_burst_lg),
      .task_stride_lg(task_stride_lg), .task_wset_lg(task_wset_lg),
      .busy(busy), .done(done), .err(err), .cycles(cycles),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
      .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
      .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
      .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(m_bvalid),
      .m_bready(m_bready), .m_bresp(m_bresp)
   );

   int n_chk = 0, n_fail = 0;

   // slave model and monitor state
   logic [63:0] cyc = '0;
   logic clr = 1'b0, thr = 1'b0;
   int   exp_n = 0, err_idx = 1000;
   logic [7:0] exp_len = '0;
   logic [ADDR_W-1:0] addr_log [64];
   int   aw_cnt, wl_cnt, b_sent, len_bad, wl_bad, sat_bad, meta_bad;
   logic [7:0] beat;
   logic [63:0] acc_cyc, last_b_cyc;

   always @(posedge clk) cyc <= cyc + 64'd1;

   always @(posedge clk) begin
      m_awready <= thr ? (cyc[0] ^ cyc[1]) : 1'b1;
      m_wready  <= thr ? (cyc[1:0] != 2'b11) : 1'b1;
      if (task_start && !busy) acc_cyc <= cyc;
      if (clr || !rst_n) begin
         aw_cnt <= 0; wl_cnt <= 0; b_sent <= 0; len_bad <= 0; wl_bad <= 0;
         sat_bad <= 0; meta_bad <= 0; beat <= '0; m_bvalid <= 1'b0; m_bresp <= 2'b00;
      end else begin
         if (m_awvalid && m_awready) begin
            if (aw_cnt < 64) addr_log[aw_cnt] <= m_awaddr;
            if (m_awlen != exp_len) len_bad <= len_bad + 1;
            if (m_awsize != 3'(BUS_LG) || m_awburst != 2'b01) meta_bad <= meta_bad + 1;
            aw_cnt <= aw_cnt + 1;
         end
         if (m_wvalid && m_wready) begin
            if (m_wstrb != '1) wl_bad <= wl_bad + 1;
            if (m_wlast) begin
               if (beat != exp_len) wl_bad <= wl_bad + 1;
               beat <= '0;
               wl_cnt <= wl_cnt + 1;
            end else begin
               if (beat == exp_len) wl_bad <= wl_bad + 1;
               beat <= beat + 8'd1;
            end
         end
         if (busy && aw_cnt < exp_n && !m_awvalid) sat_bad <= sat_bad + 1;
         if (busy && wl_cnt < exp_n && !m_wvalid) sat_bad <= sat_bad + 1;
         if (m_bvalid && m_bready) begin
            m_bvalid <= 1'b0;
            b_sent <= b_sent + 1;
            last_b_cyc <= cyc;
         end else if (!m_bvalid && b_sent < aw_cnt && b_sent < wl_cnt && cyc[0]) begin
            m_bvalid <= 1'b1;
            m_bresp  <= (b_sent == err_idx) ? 2'b10 : 2'b00;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] len_for(input int blg);
      int l = blg;
      if (l < BUS_LG) l = BUS_LG;
      if (l > BUS_LG + 8) l = BUS_LG + 8;
      return 8'((1 << (l - BUS_LG)) - 1);
   endfunction

   task automatic start_job(input logic [ADDR_W-1:0] a, input int n, input int blg,
                            input int slg, input int wlg, input logic t, input int eidx);
      @(negedge clk);
      exp_n = n; exp_len = len_for(blg); thr = t; err_idx = eidx;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      task_addr = a; task_count = CNT_W'(n); task_burst_lg = LOG_W'(blg);
      task_stride_lg = LOG_W'(slg); task_wset_lg = LOG_W'(wlg);
      task_start = 1'b1;
      @(negedge clk);
      task_start = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int t = 0;
      while (!done && t < 20000) begin
         @(negedge clk);
         t++;
      end
      if (!done) begin
         n_fail++;
         $display("FAIL %s watchdog: actual done=0 expected done=1", req);
      end
   endtask

   task automatic check_job(input string req, input logic [ADDR_W-1:0] a, input int n,
                            input int slg, input int wlg, input logic exp_err);
      logic [63:0] m = (64'd1 << wlg) - 64'd1;
      chk("R1", "address count", 64'(aw_cnt), 64'(n));
      for (int i = 0; i < n && i < 64; i++)
         chk("R1", "burst address", 64'(addr_log[i]),
             64'(ADDR_W'(64'(a) + ((64'(i) << slg) & m))));
      chk("R2", "awlen/awsize/awburst mismatches", 64'(len_bad + meta_bad), 64'd0);
      chk("R3", "burst count", 64'(wl_cnt), 64'(n));
      chk("R3", "wlast/wstrb mismatches", 64'(wl_bad), 64'd0);
      chk("R4", "valid gaps", 64'(sat_bad), 64'd0);
      chk("R5", "responses", 64'(b_sent), 64'(n));
      chk("R5", "busy after end", 64'(busy), 64'd0);
      chk("R6", "elapsed cycles", cycles, last_b_cyc - acc_cyc);
      chk("R7", "error flag", 64'(err), 64'(exp_err));
      chk(req, "done", 64'(done), 64'd1);
   endtask

   task automatic t_reset;
      chk("R10", "busy", 64'(busy), 64'd0);
      chk("R10", "done", 64'(done), 64'd0);
      chk("R10", "err", 64'(err), 64'd0);
      chk("R10", "awvalid", 64'(m_awvalid), 64'd0);
      chk("R10", "wvalid", 64'(m_wvalid), 64'd0);
      chk("R10", "cycles", cycles, 64'd0);
   endtask

   task automatic t_basic_wrap;
      start_job(32'h1000, 6, 5, 6, 8, 1'b0, 1000);
      wait_done("R1");
      check_job("R1", 32'h1000, 6, 6, 8, 1'b0);
   endtask

   task automatic t_stride_equals_window;
      start_job(32'h2340, 4, 4, 7, 7, 1'b1, 1000);
      wait_done("R1");
      check_job("R1", 32'h2340, 4, 7, 7, 1'b0);
   endtask

   task automatic t_backpressure;
      logic [63:0] c0;
      start_job(32'h0, 9, 6, 5, 12, 1'b1, 1000);
      wait_done("R4");
      check_job("R4", 32'h0, 9, 5, 12, 1'b0);
      c0 = cycles;
      repeat (4) @(negedge clk);
      chk("R6", "cycles frozen while done", cycles, c0);
   endtask

   task automatic t_error_resp;
      start_job(32'h8000, 5, 5, 5, 10, 1'b0, 2);
      wait_done("R7");
      check_job("R7", 32'h8000, 5, 5, 10, 1'b1);
      start_job(32'h8000, 2, 5, 5, 10, 1'b0, 1000);
      wait_done("R7");
      check_job("R7", 32'h8000, 2, 5, 10, 1'b0);
   endtask

   task automatic t_start_ignored;
      start_job(32'h400, 5, 5, 6, 9, 1'b1, 1000);
      repeat (3) @(negedge clk);
      chk("R8", "busy before ignored start", 64'(busy), 64'd1);
      task_addr = 32'hF000; task_count = 16'd2; task_burst_lg = 6'd8;
      task_start = 1'b1;
      @(negedge clk);
      task_start = 1'b0;
      wait_done("R8");
      check_job("R8", 32'h400, 5, 6, 9, 1'b0);
   endtask

   task automatic t_zero_count;
      start_job(32'h100, 0, 5, 5, 8, 1'b0, 1000);
      chk("R9", "done one cycle after accept", 64'(done), 64'd1);
      chk("R9", "cycles", cycles, 64'd0);
      chk("R9", "busy", 64'(busy), 64'd0);
      repeat (3) @(negedge clk);
      chk("R9", "no address traffic", 64'(aw_cnt), 64'd0);
      chk("R9", "no data traffic", 64'(wl_cnt), 64'd0);
   endtask

   task automatic t_burst_clamp;
      start_job(32'h0, 3, 2, 3, 8, 1'b0, 1000);
      wait_done("R2");
      check_job("R2", 32'h0, 3, 3, 8, 1'b0);
      start_job(32'h0, 2, 14, 12, 16, 1'b1, 1000);
      wait_done("R2");
      check_job("R2", 32'h0, 2, 12, 16, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_wrap();
      t_stride_equals_window();
      t_backpressure();
      t_error_resp();
      t_start_ignored();
      t_zero_count();
      t_burst_clamp();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule